// File: doc/BRIEF.md
# Programmable Next-State Control Matrix

This block is a table-driven phase sequencer for a hybrid analog/digital machine. The whole program is held in two writable tables. The first is a per-state attribute table, which gives each state's integrator mode word, its segment duration, a mask for the condition inputs and a stop bit. The second is a next-state table with one row per state and one column per value of the masked condition inputs. The condition inputs are single-bit digital values, for example comparator outputs or counter terminal flags.

A host loads both tables through a plain address/data/write-enable port while the sequencer is idle, then pulses start. The sequencer enters state 0 and holds each state for its programmed duration. When the duration expires, it looks up the row of the current state in the column selected by the masked conditions, and moves to the state found there. It repeats this until it reaches a state whose stop bit is set. Loading different table contents gives a different program on the same logic.

Top module: `seqmat_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and wr_err_o are 0, mode_o is 0 and state_o is 0.
- R2: A start_i pulse while idle begins a run in state 0, and busy_o reads 1 from the following cycle until the run stops.
- R3: A state that does not stop, with duration field D, occupies exactly D+4 clock cycles. A stop state takes 2 cycles from entry to done_o. The cycle count from the start edge to done_o is therefore the sum of D+4 over the states passed through, plus 2.
- R4: The next state is the entry at row = current state and column = (cond_i AND mask), with cond_i bit i forming column bit i, sampled in the last cycle of the state's duration.
- R5: A state whose mask is 0 always takes column 0, whatever cond_i holds.
- R6: On entry to a state that does not stop, mode_o takes that state's mode word. On entry to a stop state, mode_o keeps its previous value, done_o rises, busy_o falls and state_o shows the stop state.
- R7: While idle, cfg_sel=0 writes the attribute entry of state cfg_addr[3:0]. Its fields are mode in data[7:0], duration in data[15:8], mask in data[17:16] and stop in data[18]. cfg_sel=1 writes the next-state entry at row cfg_addr[5:2] and column cfg_addr[1:0], taking the target state from data[3:0].
- R8: A table write attempted while busy changes neither table and sets wr_err_o, which stays 1 until reset.
- R9: A start_i pulse while busy has no effect on the running sequence.
- R10: Loading new table contents while idle changes the sequence the next run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | Table select: 0 attributes, 1 next-state |
| cfg_addr | input | 6 | Table address |
| cfg_wdata | input | 19 | Table write data |
| start_i | input | 1 | Run start pulse |
| cond_i | input | 2 | Condition inputs |
| mode_o | output | 8 | Integrator mode word |
| state_o | output | 4 | Current state |
| busy_o | output | 1 | Sequencer running |
| done_o | output | 1 | Run ended on a stop state |
| wr_err_o | output | 1 | Sticky flag for a write refused while busy |

## Verification
A row that leaves both mask bits open is run with each of the four condition values, and each value must land on a different stop state, which shows the column is formed with the correct bit order. Rows with no mask and with one mask bit are driven with condition values that would pick other columns if masking failed. Random forward-only programs with random durations, masks, modes and stop bits are reloaded many times and run under all four condition values; matching the total cycle count, final state and final mode separates duration errors from lookup errors from mode-freeze errors. A long segment with a write and a start pulse injected mid-run shows whether either disturbs the running program.

// File: rtl/seqmat_pkg.sv
`timescale 1ns/1ps
package seqmat_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_APPLY = 3'd2,
    PH_RUN   = 3'd3,
    PH_NEXT  = 3'd4
  } phase_t;
endpackage

// File: rtl/seqmat_ram.sv
`timescale 1ns/1ps
module seqmat_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seqmat_seq.sv
`timescale 1ns/1ps
module seqmat_seq
  import seqmat_pkg::*;
#(
  parameter int N_ST   = 16,
  parameter int COND_N = 2,
  parameter int MODE_W = 8,
  parameter int DUR_W  = 8,
  localparam int ST_W   = $clog2(N_ST),
  localparam int ATTR_W = MODE_W + DUR_W + COND_N + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   cfg_we_i,
  input  logic [COND_N-1:0]      cond_i,
  input  logic [ATTR_W-1:0]      attr_q_i,
  input  logic [ST_W-1:0]        nxt_q_i,
  output logic [ST_W-1:0]        attr_raddr_o,
  output logic [ST_W+COND_N-1:0] nxt_raddr_o,
  output logic                   cfg_ok_o,
  output logic [MODE_W-1:0]      mode_o,
  output logic [ST_W-1:0]        state_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o
);
  phase_t            ph;
  logic [ST_W-1:0]   cur;
  logic [DUR_W-1:0]  cnt;
  logic [MODE_W-1:0] mode_q;
  logic              done_q, err_q;

  logic [MODE_W-1:0] a_mode;
  logic [DUR_W-1:0]  a_dur;
  logic [COND_N-1:0] a_mask;
  logic              a_stop;

  assign a_mode = attr_q_i[MODE_W-1:0];
  assign a_dur  = attr_q_i[MODE_W +: DUR_W];
  assign a_mask = attr_q_i[MODE_W+DUR_W +: COND_N];
  assign a_stop = attr_q_i[ATTR_W-1];

  assign attr_raddr_o = cur;
  assign nxt_raddr_o  = {cur, cond_i & a_mask};
  assign cfg_ok_o     = (ph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cur    <= '0;
      cnt    <= '0;
      mode_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cfg_we_i && ph != PH_IDLE) err_q <= 1'b1;
      case (ph)
        PH_IDLE: if (start_i) begin
          cur    <= '0;
          done_q <= 1'b0;
          ph     <= PH_FETCH;
        end
        PH_FETCH: ph <= PH_APPLY;
        PH_APPLY: begin
          if (a_stop) begin
            done_q <= 1'b1;
            ph     <= PH_IDLE;
          end else begin
            mode_q <= a_mode;
            cnt    <= a_dur;
            ph     <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (cnt == '0) ph <= PH_NEXT;
          else           cnt <= cnt - 1'b1;
        end
        PH_NEXT: begin
          cur <= nxt_q_i;
          ph  <= PH_FETCH;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign state_o = cur;
  assign busy_o  = (ph != PH_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R8: error flag never clears outside reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R8: a write while running is flagged
  p_busy_write_err_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && ph != PH_IDLE) |=> err_q);
  // R6: done only while idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (ph == PH_IDLE));
  // R3: segment counter steps down by one while running
  p_cnt_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RUN && cnt != '0) |=> (ph == PH_RUN && cnt == $past(cnt) - 1'b1));
  // R3: mode word held for the whole segment
  p_mode_stable_run_r3: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RUN) |=> $stable(mode_q));
  // R4: state changes only at the lookup step
  p_state_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_FETCH || ph == PH_APPLY || ph == PH_RUN) |=> $stable(cur));
  // R6: a stop entry freezes mode and ends the run
  p_stop_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_APPLY && a_stop) |=> (done_q && ph == PH_IDLE && $stable(mode_q)));
endmodule

// File: rtl/seqmat_ctrl.sv
`timescale 1ns/1ps
module seqmat_ctrl #(
  parameter int N_ST   = 16,
  parameter int COND_N = 2,
  parameter int MODE_W = 8,
  parameter int DUR_W  = 8,
  localparam int ST_W   = $clog2(N_ST),
  localparam int NX_AW  = ST_W + COND_N,
  localparam int NX_D   = N_ST * (2 ** COND_N),
  localparam int ATTR_W = MODE_W + DUR_W + COND_N + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [NX_AW-1:0]  cfg_addr,
  input  logic [ATTR_W-1:0] cfg_wdata,
  input  logic              start_i,
  input  logic [COND_N-1:0] cond_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [ST_W-1:0]   state_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              wr_err_o
);
  logic              cfg_ok;
  logic [ATTR_W-1:0] attr_q;
  logic [ST_W-1:0]   nxt_q;
  logic [ST_W-1:0]   attr_raddr;
  logic [NX_AW-1:0]  nxt_raddr;
  logic              attr_we, nxt_we;

  assign attr_we = cfg_we && cfg_ok && !cfg_sel;
  assign nxt_we  = cfg_we && cfg_ok &&  cfg_sel;

  seqmat_ram #(.W(ATTR_W), .DEPTH(N_ST)) attr_ram_i (
    .clk(clk), .we(attr_we), .waddr(cfg_addr[ST_W-1:0]), .wdata(cfg_wdata),
    .raddr(attr_raddr), .rdata(attr_q));

  seqmat_ram #(.W(ST_W), .DEPTH(NX_D)) nxt_ram_i (
    .clk(clk), .we(nxt_we), .waddr(cfg_addr), .wdata(cfg_wdata[ST_W-1:0]),
    .raddr(nxt_raddr), .rdata(nxt_q));

  seqmat_seq #(.N_ST(N_ST), .COND_N(COND_N), .MODE_W(MODE_W), .DUR_W(DUR_W)) seq_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_we_i(cfg_we), .cond_i(cond_i),
    .attr_q_i(attr_q), .nxt_q_i(nxt_q), .attr_raddr_o(attr_raddr),
    .nxt_raddr_o(nxt_raddr), .cfg_ok_o(cfg_ok), .mode_o(mode_o),
    .state_o(state_o), .busy_o(busy_o), .done_o(done_o), .err_o(wr_err_o));
endmodule

// File: tb/seqmat_ctrl_tb.sv
`timescale 1ns/1ps
module seqmat_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [18:0] cfg_wdata = '0;
  logic        start_i = 1'b0;
  logic [1:0]  cond_i = '0;
  logic [7:0]  mode_o;
  logic [3:0]  state_o;
  logic        busy_o, done_o, wr_err_o;

  int n_chk = 0, n_fail = 0, cyc_total = 0;
  logic [7:0] last_mode = '0;

  bit [7:0] m_mode [16];
  int       m_dur  [16];
  bit [1:0] m_mask [16];
  bit       m_stop [16];
  int       m_next [16][4];

  seqmat_ctrl dut_i (.*);

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 150000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog R3: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [5:0] a, input logic [18:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_all();
    for (int s = 0; s < 16; s++) begin
      wr(1'b0, 6'(s), {m_stop[s], m_mask[s], 8'(m_dur[s]), m_mode[s]});
      for (int c = 0; c < 4; c++)
        wr(1'b1, {4'(s), 2'(c)}, 19'(m_next[s][c]));
    end
  endtask

  task automatic clear_prog();
    for (int s = 0; s < 16; s++) begin
      m_stop[s] = 1'b1; m_mask[s] = 2'b00; m_dur[s] = 0; m_mode[s] = 8'(s);
      for (int c = 0; c < 4; c++) m_next[s][c] = 0;
    end
  endtask

  task automatic model(input logic [1:0] cnd, output int cyc, output int st,
                       output logic [7:0] md);
    int s = 0;
    cyc = 0; md = last_mode;
    for (int k = 0; k < 64; k++) begin
      if (m_stop[s]) begin cyc += 2; break; end
      md = m_mode[s];
      cyc += m_dur[s] + 4;
      s = m_next[s][int'(cnd & m_mask[s])];
    end
    st = s;
  endtask

  task automatic run_chk(input logic [1:0] cnd, input string tag, input bit disturb);
    int ecyc, est, n;
    logic [7:0] emd;
    model(cnd, ecyc, est, emd);
    cond_i = cnd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R2 busy after start"}, int'(busy_o), 1);
    n = 0;
    do begin
      if (disturb && n == 3) begin
        start_i = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = 6'd1; cfg_wdata = '0;
      end else begin
        start_i = 1'b0; cfg_we = 1'b0;
      end
      @(negedge clk);
      n++;
    end while (!done_o && n < 5000);
    start_i = 1'b0; cfg_we = 1'b0;
    chk({tag, " R3 cycles to done"}, n, ecyc);
    chk({tag, " R4 final state"}, int'(state_o), est);
    chk({tag, " R6 final mode"}, int'(mode_o), int'(emd));
    chk({tag, " R6 busy low at done"}, int'(busy_o), 0);
    last_mode = emd;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 wr_err", int'(wr_err_o), 0);
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 state", int'(state_o), 0);

    // R4/R7: full mask, each column to its own stop state
    clear_prog();
    m_stop[0] = 0; m_mask[0] = 2'b11; m_dur[0] = 2; m_mode[0] = 8'hA5;
    for (int c = 0; c < 4; c++) m_next[0][c] = 4 + c;
    load_all();
    for (int c = 0; c < 4; c++) run_chk(2'(c), "R4 column", 1'b0);

    // R5: fully masked row ignores conditions
    m_mask[0] = 2'b00;
    load_all();
    run_chk(2'b11, "R5 masked cond3", 1'b0);
    run_chk(2'b10, "R5 masked cond2", 1'b0);
    chk("R5 masked goes to column 0 state", int'(state_o), 4);

    // R4: partial mask keeps bit 0 only
    m_mask[0] = 2'b01;
    load_all();
    run_chk(2'b10, "R4 partial mask cond2", 1'b0);
    run_chk(2'b11, "R4 partial mask cond3", 1'b0);

    // R3 duration extremes, R6 first state stops keeps mode
    m_mask[0] = 2'b00; m_dur[0] = 255; m_mode[0] = 8'h3C;
    load_all();
    run_chk(2'b00, "R3 max duration", 1'b0);
    m_dur[0] = 0;
    load_all();
    run_chk(2'b00, "R3 zero duration", 1'b0);
    m_stop[0] = 1;
    load_all();
    run_chk(2'b01, "R6 immediate stop keeps mode", 1'b0);

    // R8/R9: write and start during a run are ignored
    clear_prog();
    m_stop[0] = 0; m_dur[0] = 40; m_mode[0] = 8'h77;
    for (int c = 0; c < 4; c++) m_next[0][c] = 1;
    m_stop[2] = 0; m_dur[2] = 9;
    load_all();
    run_chk(2'b00, "R8 R9 disturbed run", 1'b1);
    chk("R8 wr_err set by busy write", int'(wr_err_o), 1);
    run_chk(2'b00, "R8 entry unchanged rerun", 1'b0);
    wr(1'b0, 6'd5, 19'h0);
    chk("R8 wr_err sticky", int'(wr_err_o), 1);

    // R10: random forward programs reloaded and run
    for (int p = 0; p < 20; p++) begin
      for (int s = 0; s < 16; s++) begin
        m_stop[s] = (s == 15) || ($urandom % 5 == 0);
        m_mask[s] = 2'($urandom);
        m_dur[s]  = int'($urandom % 8);
        m_mode[s] = 8'($urandom);
        for (int c = 0; c < 4; c++)
          m_next[s][c] = (s < 15) ? s + 1 + int'($urandom % (15 - s)) : 0;
      end
      load_all();
      for (int c = 0; c < 4; c++) run_chk(2'(c), "R10 random program", 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule